// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block watches a 20-bit external bus address and picks one of six memory regions for it. Each region has three registers. A compare register holds the region's page address, which is address bits 19..8. A mask register chooses which of those page bits count toward a match. A bus-control register gives the settings that apply to the region: multiplexed or demultiplexed bus, 8- or 16-bit width, and a wait-state count. When the address falls inside a region, the block pulls that region's active-low select low and drives the region's bus settings to the bus sequencer.

Software reaches the registers through a simple word read/write port. After reset, region 0 covers a single 256-byte boot window with slow 8-bit settings, so the first configuration byte can be fetched. A separate load strobe then copies the low nibble of that configuration byte into region 0's bus-control register.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset, the register read port returns these values. Compare 0 is 0F20h and compares 1..5 are 0000h. Every mask is 0FFFh. Bus-control 0 is 0003h and bus-controls 1..5 are 0000h.
- R2: The register map uses a stride of 8 bytes per channel x (0..5). Compare x is at 1F40h+8x, mask x at 1F42h+8x and bus-control x at 1F44h+8x. Compare and mask hold 12 bits (wdata[11:0]) and bus-control holds 4 bits (wdata[3:0]). Unimplemented upper bits read as zero, and any other address reads zero and ignores writes.
- R3: Channel x matches when ((addr[19:8] XOR compare_x) AND mask_x) is zero, so a page bit whose mask bit is 0 does not affect the match.
- R4: When several channels match, only the lowest-numbered one drives its select low. At most one select is ever low.
- R5: When no channel matches, all selects stay high and no_match is 1. The demux, width and wait-state outputs are then all 0.
- R6: When a channel wins, its bus-control bits drive the outputs. Bit 3 drives bus_demux (1 = demultiplexed) and bit 2 drives bus_bw16 (1 = 16-bit). Bits 1:0 drive bus_ws, which is the wait-state count 0..3.
- R7: The selects and bus settings are registered. They reflect the address present at a clock edge and the register contents from before any write in that same cycle, and they appear after that edge.
- R8: When cfg_ld is high at a clock edge, bus-control 0 takes cfg_byte[3:0]. This overrides a register write to bus-control 0 in the same cycle.
- R9: After reset, addresses F2000h..F20FFh select channel 0 with a multiplexed 8-bit bus and 3 wait states. Address F2100h matches no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | External bus address to decode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register port address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| cfg_ld | input | 1 | Configuration-byte load strobe for bus-control 0 |
| cfg_byte | input | 8 | Configuration byte; bits 3:0 are used |
| cs_n | output | 6 | Active-low chip selects, one per channel |
| bus_demux | output | 1 | Winning region uses a demultiplexed bus |
| bus_bw16 | output | 1 | Winning region is 16 bits wide |
| bus_ws | output | 2 | Wait-state count of the winning region |
| no_match | output | 1 | No region matched the address |

## Verification
The bench creates overlapping regions with different settings to check that the lower channel always wins. A design that got this wrong would assert two selects at once or mix settings from both regions. Partial masks are exercised to confirm that a cleared mask bit is a don't-care; a design that inverted the mask sense would miss whole address ranges. Two cases target timing. A register write in the same cycle as a decode must not affect that decode, and a configuration load must beat a simultaneous write to bus-control 0. A design with the wrong write priority would read back the written value instead of the configuration nibble.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Bus settings of one region; bit order matches the bus-control register
    typedef struct packed {
        logic       demux;  // bit 3
        logic       bw16;   // bit 2
        logic [1:0] ws;     // bits 1:0
    } busprm_t;

    localparam int BCR_W = $bits(busprm_t);

    localparam logic [11:0] CMP0_RST = 12'hF20;
    localparam busprm_t     BCR0_RST = '{demux: 1'b0, bw16: 1'b0, ws: 2'd3};

endpackage

// File: rtl/csd_match.sv
module csd_match #(
    parameter int PW = 12
) (
    input  logic [PW-1:0] page,
    input  logic [PW-1:0] cmp,
    input  logic [PW-1:0] msk,
    output logic          hit
);
    assign hit = ~|((page ^ cmp) & msk);
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
        any = taken;
    end
endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import csd_pkg::*;
#(
    parameter int             NCH      = 6,
    parameter int             AW       = 20,
    parameter int             PW       = 12,
    parameter int             RAW      = 16,
    parameter int             DW       = 16,
    parameter int             STRIDE   = 8,
    parameter logic [RAW-1:0] REG_BASE = 16'h1F40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            cfg_ld,
    input  logic [7:0]      cfg_byte,
    output logic [NCH-1:0]  cs_n,
    output logic            bus_demux,
    output logic            bus_bw16,
    output logic [1:0]      bus_ws,
    output logic            no_match
);
    localparam int OFS_MSK = 2;
    localparam int OFS_BCR = 4;

    typedef struct packed {
        logic    [NCH-1:0][PW-1:0] cmp;
        logic    [NCH-1:0][PW-1:0] msk;
        busprm_t [NCH-1:0]         bcr;
        logic    [NCH-1:0]         cs_n;
        busprm_t                   prm;
        logic                      nomatch;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NCH; i++) begin
            s.msk[i] = '1;
        end
        s.cmp[0]  = CMP0_RST;
        s.bcr[0]  = BCR0_RST;
        s.cs_n    = '1;
        s.nomatch = 1'b1;
        return s;
    endfunction

    function automatic logic [RAW-1:0] reg_at(input int ch, input int ofs);
        return REG_BASE + RAW'(STRIDE * ch + ofs);
    endfunction

    state_t state_d, state_q;

    logic [NCH-1:0] hit, gnt;
    logic           any_hit;
    busprm_t        sel_prm;

    // per-channel compare
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        csd_match #(.PW(PW)) u_match (
            .page (bus_addr[AW-1:AW-PW]),
            .cmp  (state_q.cmp[g]),
            .msk  (state_q.msk[g]),
            .hit  (hit[g])
        );
    end

    csd_prio #(.N(NCH)) u_prio (
        .req (hit),
        .gnt (gnt),
        .any (any_hit)
    );

    always_comb begin
        sel_prm = '0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt[i]) sel_prm = state_q.bcr[i];
        end
    end

    // next-state computation
    always_comb begin
        state_d = state_q;

        for (int i = 0; i < NCH; i++) begin
            if (reg_we && reg_addr == reg_at(i, 0))
                state_d.cmp[i] = reg_wdata[PW-1:0];
            if (reg_we && reg_addr == reg_at(i, OFS_MSK))
                state_d.msk[i] = reg_wdata[PW-1:0];
            if (reg_we && reg_addr == reg_at(i, OFS_BCR))
                state_d.bcr[i] = busprm_t'(reg_wdata[BCR_W-1:0]);
        end
        if (cfg_ld) state_d.bcr[0] = busprm_t'(cfg_byte[BCR_W-1:0]);

        state_d.cs_n    = ~gnt;
        state_d.prm     = any_hit ? sel_prm : '0;
        state_d.nomatch = ~any_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == reg_at(i, 0))
                reg_rdata = {{(DW-PW){1'b0}}, state_q.cmp[i]};
            if (reg_addr == reg_at(i, OFS_MSK))
                reg_rdata = {{(DW-PW){1'b0}}, state_q.msk[i]};
            if (reg_addr == reg_at(i, OFS_BCR))
                reg_rdata = {{(DW-BCR_W){1'b0}}, state_q.bcr[i]};
        end
    end

    busprm_t bcr0_q;
    assign bcr0_q    = state_q.bcr[0];

    assign cs_n      = state_q.cs_n;
    assign bus_demux = state_q.prm.demux;
    assign bus_bw16  = state_q.prm.bw16;
    assign bus_ws    = state_q.prm.ws;
    assign no_match  = state_q.nomatch;

    logic unused_bits;
    assign unused_bits = ^{cfg_byte[7:BCR_W], reg_wdata[DW-1:PW], bus_addr[AW-PW-1:0]};

endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cs_n,
    input logic           no_match,
    input logic           bus_demux,
    input logic           bus_bw16,
    input logic [1:0]     bus_ws,
    input logic           cfg_ld,
    input logic [3:0]     cfg_nib,
    input logic [3:0]     bcr0
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));                                         // R4

    AST_NOMATCH_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        no_match == (&cs_n));                                     // R5

    AST_NOMATCH_PARAMS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> ({bus_demux, bus_bw16, bus_ws} == 4'h0));    // R5

    AST_CFG_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ld |=> (bcr0 == $past(cfg_nib)));                     // R8
endmodule

bind cs_region_decoder csd_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .no_match  (no_match),
    .bus_demux (bus_demux),
    .bus_bw16  (bus_bw16),
    .bus_ws    (bus_ws),
    .cfg_ld    (cfg_ld),
    .cfg_nib   (cfg_byte[3:0]),
    .bcr0      (bcr0_q)
);

// File: tb/cs_region_decoder_tb.sv
module cs_region_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cfg_ld = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic [5:0]  cs_n;
    logic        bus_demux, bus_bw16, no_match;
    logic [1:0]  bus_ws;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_region_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cfg_ld(cfg_ld), .cfg_byte(cfg_byte),
        .cs_n(cs_n), .bus_demux(bus_demux), .bus_bw16(bus_bw16),
        .bus_ws(bus_ws), .no_match(no_match)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural model
    int m_cmp[6], m_msk[6], m_bcr[6];
    int e_cs, e_prm, e_nm;

    function automatic int model_read(input int a);
        for (int i = 0; i < 6; i++) begin
            if (a == 'h1F40 + 8*i) return m_cmp[i];
            if (a == 'h1F42 + 8*i) return m_msk[i];
            if (a == 'h1F44 + 8*i) return m_bcr[i];
        end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin
                m_cmp[i] = 0; m_msk[i] = 'hFFF; m_bcr[i] = 0;
            end
            m_cmp[0] = 'hF20; m_bcr[0] = 3;
            e_cs = 'h3F; e_prm = 0; e_nm = 1;
        end else begin
            int win;
            int pg;
            win = -1;
            pg  = int'(bus_addr[19:8]);
            for (int i = 0; i < 6; i++)
                if (win < 0 && (((pg ^ m_cmp[i]) & m_msk[i]) == 0)) win = i;
            e_cs  = (win < 0) ? 'h3F : ('h3F & ~(1 << win));
            e_prm = (win < 0) ? 0 : m_bcr[win];
            e_nm  = (win < 0) ? 1 : 0;
            if (reg_we) begin
                for (int i = 0; i < 6; i++) begin
                    if (int'(reg_addr) == 'h1F40 + 8*i) m_cmp[i] = int'(reg_wdata) & 'hFFF;
                    if (int'(reg_addr) == 'h1F42 + 8*i) m_msk[i] = int'(reg_wdata) & 'hFFF;
                    if (int'(reg_addr) == 'h1F44 + 8*i) m_bcr[i] = int'(reg_wdata) & 'hF;
                end
            end
            if (cfg_ld) m_bcr[0] = int'(cfg_byte) & 'hF;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 cs_n", int'(cs_n), e_cs);
        chk("R6 params", int'({bus_demux, bus_bw16, bus_ws}), e_prm);
        chk("R5 no_match", int'(no_match), e_nm);
        chk("R2 rdata", int'(reg_rdata), model_read(int'(reg_addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 16'(a); reg_wdata = 16'(d);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        reg_addr = 16'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;

        // R1 reset register contents
        rd_chk("R1 cmp0", 'h1F40, 'h0F20);
        rd_chk("R1 msk0", 'h1F42, 'h0FFF);
        rd_chk("R1 bcr0", 'h1F44, 'h0003);
        rd_chk("R1 cmp3", 'h1F58, 'h0000);
        rd_chk("R1 msk5", 'h1F6A, 'h0FFF);
        rd_chk("R1 bcr5", 'h1F6C, 'h0000);
        rd_chk("R2 unmapped", 'h1F46, 'h0000);

        // R9 boot window
        bus_addr = 20'hF20FF; tick();
        chk("R9 cs0 boot", int'(cs_n), 'h3E);
        chk("R9 boot params", int'({bus_demux, bus_bw16, bus_ws}), 3);
        bus_addr = 20'hF2100; tick();
        chk("R9 outside window", int'(no_match), 1);

        // R4 overlap: ch1 same window, different params
        wr('h1F48, 'hFF20);
        rd_chk("R2 upper bits zero", 'h1F48, 'h0F20);
        wr('h1F4C, 'h00FF);
        rd_chk("R2 bcr width", 'h1F4C, 'h000F);
        bus_addr = 20'hF2010; tick();
        chk("R4 lowest wins", int'(cs_n), 'h3E);
        chk("R4 lowest params", int'(bus_ws), 3);

        // R6 ch1 alone
        wr('h1F48, 'h0A10);
        bus_addr = 20'hA1055; tick();
        chk("R6 cs1", int'(cs_n), 'h3D);
        chk("R6 demux", int'(bus_demux), 1);
        chk("R6 bw16", int'(bus_bw16), 1);

        // R3 masked compare
        wr('h1F52, 'h0F00);
        wr('h1F50, 'h03FF);
        bus_addr = 20'h3ABCD; tick();
        chk("R3 masked hit", int'(cs_n), 'h3B);
        bus_addr = 20'h4ABCD; tick();
        chk("R3 masked miss", int'(no_match), 1);
        chk("R5 params zero", int'({bus_demux, bus_bw16, bus_ws}), 0);

        // R7 registered output
        bus_addr = 20'hF2000;
        #1;
        chk("R7 not yet", int'(no_match), 1);
        tick();
        chk("R7 after edge", int'(cs_n), 'h3E);
        // write in same cycle as decode does not affect it
        reg_we = 1'b1; reg_addr = 16'h1F40; reg_wdata = 16'h0123;
        tick();
        reg_we = 1'b0;
        chk("R7 old regs used", int'(cs_n), 'h3E);
        tick();
        chk("R7 new regs used", int'(no_match), 1);
        wr('h1F40, 'h0F20);

        // R8 config load overrides write
        reg_we = 1'b1; reg_addr = 16'h1F44; reg_wdata = 16'h0005;
        cfg_ld = 1'b1; cfg_byte = 8'hFC;
        tick();
        reg_we = 1'b0; cfg_ld = 1'b0;
        rd_chk("R8 bcr0 from cfg", 'h1F44, 'h000C);
        bus_addr = 20'hF2000; tick();
        chk("R8 params applied", int'({bus_demux, bus_bw16, bus_ws}), 'hC);

        // random phase, model compared each cycle
        for (int n = 0; n < 600; n++) begin
            int ch;
            int r;
            ch = int'($urandom % 6);
            r  = int'($urandom % 100);
            reg_we = (r < 30);
            case ($urandom % 4)
                0: reg_addr = 16'('h1F40 + 8*ch);
                1: reg_addr = 16'('h1F42 + 8*ch);
                2: reg_addr = 16'('h1F44 + 8*ch);
                default: reg_addr = 16'('h1F40 + ($urandom % 64));
            endcase
            reg_wdata = 16'($urandom);
            if (($urandom % 16) == 0) reg_wdata[11:0] = 12'h000;
            cfg_ld   = (($urandom % 20) == 0);
            cfg_byte = 8'($urandom);
            if ($urandom % 4 != 0)
                bus_addr = {12'(model_read('h1F40 + 8*int'($urandom % 6))), 8'($urandom)};
            else
                bus_addr = 20'($urandom);
            tick();
        end
        reg_we = 1'b0; cfg_ld = 1'b0;
        tick();
        finish_run();
    end
endmodule